// File: doc/BRIEF.md
# Programmable Periodic Interrupt Timer

The block is a down-counting timer driven through a small register file. Software writes a period value and loads it into the counter with one operation code. It starts counting with a second code and halts it with a third. A frequency field selects the count rate: every clock, every `PRESCALE` clocks, or no counting at all. When a period ends the counter raises a sticky raw interrupt flag. In the same cycle it refills itself from the current period register, so interrupts repeat with no software action beyond acknowledging them.

The interrupt path has four parts: the raw flag, an enable mask, a read-only view of the raw flag after masking, and a write-one-to-clear acknowledge. The interrupt pin is the masked flag. The counter value can be read at any time. Because it counts down, the time since the last refill is (period − count) ticks; at 100 MHz one tick is 10 ns. The period register may be rewritten while the timer runs, and the new value is picked up at the next refill.

Top module: `periodic_timer`

## Requirements
- R1: After reset the counter, period, control read-back, mask and raw flag all read 0 and `irq_o` is low.
- R2: A control write (op in bits [1:0]) with op 1 copies the period register into the counter. Op 2 starts counting and op 0 stops it. While stopped, the counter holds its value.
- R3: At full rate, a running counter loaded with period D > 1 reads D − (k mod D) k cycles after the run write, so the period is D cycles.
- R4: The raw flag (address 4, bit 0) is set in the cycle the counter refills. A period of D raises it D cycles after the run write.
- R5: A period write while running leaves the counter unchanged. The new period is used at the next refill.
- R6: The mask (address 3, bit 0) gates the interrupt. `irq_o` and the masked status (address 5, bit 0) are high only when the raw flag and the mask are both 1.
- R7: Writing 1 to bit 0 of the acknowledge address (6) clears the raw flag. Writing 0 there has no effect.
- R8: If a refill and an acknowledge fall in the same cycle, the raw flag stays set.
- R9: The frequency field (control bits [3:2]) selects the count rate: 0 means no counting, 1 means every clock, 2 means once every `PRESCALE` clocks.
- R10: A period of 0 or 1 refills and sets the raw flag on every tick, and the counter keeps reading the period value.
- R11: The control address reads the frequency field in bits [3:2] and the running state in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address: 0 period, 1 control, 2 count, 3 mask, 4 raw, 5 masked, 6 acknowledge |
| wdata_i | input | W | Write data |
| rdata_o | output | W | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Masked interrupt |

## Verification
The refill that sets the raw flag and a software acknowledge can land on the same clock edge. The bench loads a period of 5 and starts the timer. It then counts edges so that the acknowledge write is captured exactly on the fifth edge, when the refill happens. The raw flag must still read 1 after that edge. A second acknowledge one cycle later, with no refill pending, must clear it.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_PERIOD = 3'd0;
  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd1;
  localparam logic [ADDR_W-1:0] A_COUNT  = 3'd2;
  localparam logic [ADDR_W-1:0] A_MASK   = 3'd3;
  localparam logic [ADDR_W-1:0] A_RAW    = 3'd4;
  localparam logic [ADDR_W-1:0] A_MASKED = 3'd5;
  localparam logic [ADDR_W-1:0] A_ACK    = 3'd6;

  localparam logic [1:0] OP_STOP = 2'd0;
  localparam logic [1:0] OP_LOAD = 2'd1;
  localparam logic [1:0] OP_RUN  = 2'd2;

  localparam logic [1:0] FQ_OFF  = 2'd0;
  localparam logic [1:0] FQ_FULL = 2'd1;
  localparam logic [1:0] FQ_SLOW = 2'd2;
endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen
  import timer_pkg::*;
#(
  parameter int PRESCALE = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] freq_i,
  output logic       tick_o
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  logic slow_tick;

  generate
    if (PRESCALE > 1) begin : g_pre
      logic [PW-1:0] pre_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                          pre_q <= '0;
        else if (pre_q == PW'(PRESCALE - 1))  pre_q <= '0;
        else                                  pre_q <= pre_q + PW'(1);
      end
      assign slow_tick = (pre_q == PW'(PRESCALE - 1));
    end else begin : g_nopre
      assign slow_tick = 1'b1;
    end
  endgenerate

  always_comb begin
    case (freq_i)
      FQ_FULL: tick_o = 1'b1;
      FQ_SLOW: tick_o = slow_tick;
      default: tick_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         load_i,
  input  logic         run_i,
  input  logic         stop_i,
  input  logic [W-1:0] period_i,
  output logic [W-1:0] count_o,
  output logic         running_o,
  output logic         expire_o
);
  logic [W-1:0] count_q;
  logic         running_q;

  // a count of 0 or 1 ends the period on this tick
  assign expire_o = running_q & tick_i & (count_q <= W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     running_q <= 1'b0;
    else if (stop_i) running_q <= 1'b0;
    else if (run_i)  running_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  count_q <= '0;
    else if (load_i)              count_q <= period_i;
    else if (expire_o)            count_q <= period_i;
    else if (running_q && tick_i) count_q <= count_q - W'(1);
  end

  assign count_o   = count_q;
  assign running_o = running_q;
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic ack_i,
  input  logic mask_we_i,
  input  logic mask_d_i,
  output logic raw_o,
  output logic mask_o,
  output logic irq_o
);
  logic raw_q, mask_q;

  // set has priority over acknowledge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    raw_q <= 1'b0;
    else if (set_i) raw_q <= 1'b1;
    else if (ack_i) raw_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mask_q <= 1'b0;
    else if (mask_we_i) mask_q <= mask_d_i;
  end

  assign raw_o  = raw_q;
  assign mask_o = mask_q;
  assign irq_o  = raw_q & mask_q;
endmodule

// File: rtl/periodic_timer.sv
module periodic_timer
  import timer_pkg::*;
#(
  parameter int W        = 32,
  parameter int PRESCALE = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      wdata_i,
  output logic [W-1:0]      rdata_o,
  output logic              irq_o
);
  logic [W-1:0] period_q, count;
  logic [1:0]   freq_q, op;
  logic         wr_period, wr_ctrl, wr_mask, wr_ack;
  logic         load_cmd, run_cmd, stop_cmd, ack_hit;
  logic         tick, expire, running, raw, mask;

  assign wr_period = we_i && (addr_i == A_PERIOD);
  assign wr_ctrl   = we_i && (addr_i == A_CTRL);
  assign wr_mask   = we_i && (addr_i == A_MASK);
  assign wr_ack    = we_i && (addr_i == A_ACK);

  assign op       = wdata_i[1:0];
  assign load_cmd = wr_ctrl && (op == OP_LOAD);
  assign run_cmd  = wr_ctrl && (op == OP_RUN);
  assign stop_cmd = wr_ctrl && (op != OP_LOAD) && (op != OP_RUN);
  assign ack_hit  = wr_ack && wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        period_q <= '0;
    else if (wr_period) period_q <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      freq_q <= FQ_OFF;
    else if (wr_ctrl) freq_q <= wdata_i[3:2];
  end

  tmr_tick_gen #(.PRESCALE(PRESCALE)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .freq_i (freq_q),
    .tick_o (tick)
  );

  tmr_core #(.W(W)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .load_i    (load_cmd),
    .run_i     (run_cmd),
    .stop_i    (stop_cmd),
    .period_i  (period_q),
    .count_o   (count),
    .running_o (running),
    .expire_o  (expire)
  );

  tmr_irq u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (expire),
    .ack_i     (ack_hit),
    .mask_we_i (wr_mask),
    .mask_d_i  (wdata_i[0]),
    .raw_o     (raw),
    .mask_o    (mask),
    .irq_o     (irq_o)
  );

  always_comb begin
    case (addr_i)
      A_PERIOD: rdata_o = period_q;
      A_CTRL:   rdata_o = W'({freq_q, 1'b0, running});
      A_COUNT:  rdata_o = count;
      A_MASK:   rdata_o = W'(mask);
      A_RAW:    rdata_o = W'(raw);
      A_MASKED: rdata_o = W'(raw & mask);
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/periodic_timer_chk.sv
module tmr_periodic_chk #(
  parameter int W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         irq_o,
  input logic         raw,
  input logic         mask,
  input logic         running,
  input logic         tick,
  input logic         expire,
  input logic         load_cmd,
  input logic         ack_hit,
  input logic [1:0]   freq_q,
  input logic [W-1:0] count
);
  // R4
  set_raw_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire |=> raw);

  // R8
  set_beats_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire && ack_hit) |=> raw);

  // R7
  ack_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raw && ack_hit && !expire) |=> !raw);

  // R4
  raw_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(raw) |-> $past(expire));

  // R3
  count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running && tick && (count > W'(1)) && !load_cmd) |=> (count == $past(count) - W'(1)));

  // R2
  stopped_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!running && !load_cmd) |=> $stable(count));

  // R6
  mask_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mask |-> !irq_o);

  // R9
  freq_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (freq_q == 2'd0) |-> !tick);
endmodule

bind periodic_timer tmr_periodic_chk #(.W(W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .irq_o    (irq_o),
  .raw      (raw),
  .mask     (mask),
  .running  (running),
  .tick     (tick),
  .expire   (expire),
  .load_cmd (load_cmd),
  .ack_hit  (ack_hit),
  .freq_q   (freq_q),
  .count    (count)
);

// File: tb/periodic_timer_test.sv
module periodic_timer_test;
  localparam int PRE = 4;
  localparam int NV  = 9;
  // period, cycles after run write, expected count, expected raw flag
  localparam int VEC [NV][4] = '{
    '{5,   1,  4, 0},
    '{5,   4,  1, 0},
    '{5,   5,  5, 1},
    '{5,   7,  3, 1},
    '{1,   3,  1, 1},
    '{3,   9,  3, 1},
    '{8,   2,  6, 0},
    '{0,   2,  0, 1},
    '{100, 50, 50, 0}
  };

  logic        clk = 1'b0;
  logic        rst_ni;
  logic        we;
  logic [2:0]  addr;
  logic [31:0] wdata, rdata, v, c0;
  logic        irq;
  int          checks = 0, fails = 0, n;
  bit          done = 0;

  always #5 clk = ~clk;

  periodic_timer #(.W(32), .PRESCALE(PRE)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [31:0] ctrl(input logic [1:0] op, input logic [1:0] fq);
    return {28'd0, fq, op};
  endfunction

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1; we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic start(input int d, input logic [1:0] fq);
    wr(3'd1, ctrl(2'd0, fq));
    wr(3'd6, 32'd1);
    wr(3'd0, d);
    wr(3'd1, ctrl(2'd1, fq));
    wr(3'd1, ctrl(2'd2, fq));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_ni = 1'b1;

    // R1 reset state
    rd(3'd2, v); chk("R1 count", v, 0);
    rd(3'd0, v); chk("R1 period", v, 0);
    rd(3'd1, v); chk("R1 ctrl", v, 0);
    rd(3'd3, v); chk("R1 mask", v, 0);
    rd(3'd4, v); chk("R1 raw", v, 0);
    chk("R1 irq", irq, 0);

    // table walk: R2 load, R3 count, R4 raw, R10 short periods
    for (int i = 0; i < NV; i++) begin
      wr(3'd1, ctrl(2'd0, 2'd1));
      wr(3'd6, 32'd1);
      wr(3'd0, VEC[i][0]);
      wr(3'd1, ctrl(2'd1, 2'd1));
      rd(3'd2, v); chk("R2 load", v, VEC[i][0]);
      wr(3'd1, ctrl(2'd2, 2'd1));
      repeat (VEC[i][1]) @(posedge clk);
      @(negedge clk);
      rd(3'd2, v); chk((VEC[i][0] <= 1) ? "R10 count" : "R3 count", v, VEC[i][2]);
      rd(3'd4, v); chk((VEC[i][0] <= 1) ? "R10 raw" : "R4 raw", v, VEC[i][3]);
    end

    // R11 read-back while running then stopped
    rd(3'd1, v); chk("R11 ctrl run", v, 32'h5);
    wr(3'd1, ctrl(2'd0, 2'd1));
    rd(3'd1, v); chk("R11 ctrl stop", v, 32'h4);

    // R2 stop holds the counter
    rd(3'd2, c0);
    repeat (5) @(posedge clk);
    @(negedge clk);
    rd(3'd2, v); chk("R2 hold", v, c0);

    // R6 mask gating
    start(3, 2'd1);
    repeat (10) @(posedge clk);
    wr(3'd1, ctrl(2'd0, 2'd1));
    rd(3'd4, v); chk("R6 raw pending", v, 1);
    rd(3'd5, v); chk("R6 masked off", v, 0);
    chk("R6 irq masked", irq, 0);
    wr(3'd3, 32'd1);
    rd(3'd5, v); chk("R6 masked on", v, 1);
    chk("R6 irq on", irq, 1);

    // R7 acknowledge
    wr(3'd6, 32'd0);
    rd(3'd4, v); chk("R7 ack zero ignored", v, 1);
    wr(3'd6, 32'd1);
    rd(3'd4, v); chk("R7 ack clears", v, 0);
    chk("R7 irq low", irq, 0);

    // R8 refill and acknowledge on the same edge
    start(5, 2'd1);
    repeat (4) @(posedge clk);
    wr(3'd6, 32'd1);
    rd(3'd4, v); chk("R8 set wins", v, 1);
    rd(3'd2, v); chk("R8 refilled", v, 5);
    wr(3'd6, 32'd1);
    rd(3'd4, v); chk("R7 later ack", v, 0);

    // R5 period rewrite while running
    start(4, 2'd1);
    wr(3'd0, 32'd6);
    rd(3'd2, v); chk("R5 count untouched", v, 3);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rd(3'd2, v); chk("R5 new period at refill", v, 6);
    rd(3'd4, v); chk("R5 raw at refill", v, 1);

    // R9 frequency off: no counting
    start(7, 2'd0);
    repeat (6) @(posedge clk);
    @(negedge clk);
    rd(3'd2, v); chk("R9 off holds", v, 7);
    rd(3'd1, v); chk("R11 ctrl off run", v, 32'h1);

    // R9 slow rate: period 2 ticks of PRE clocks
    start(2, 2'd2);
    n = 0;
    while (!irq && n < 100) begin @(posedge clk); #1; n++; end
    wr(3'd6, 32'd1);
    n = 1;
    while (n < 40) begin
      @(negedge clk);
      if (irq) break;
      @(posedge clk);
      n++;
    end
    chk("R9 slow interval", n, 2 * PRE);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule